// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a small two-level logic array whose function is set at run time. A configuration image is shifted in one bit per clock. It holds two planes. The product plane holds, for every product term and every data input, a two-bit literal code. The sum plane holds, for every output and every term, one connection bit. Once loaded, the outputs follow the data inputs combinationally, through the AND of the selected literals and then the OR of the connected terms.

A parameter picks one of two sum-plane variants:

- **Shared mode:** any term can reach any output, so one term can serve several outputs.
- **Grouped mode:** each output reaches only its own fixed, contiguous group of terms.

While an image is being shifted in, the outputs are forced low so that no partial personality is seen downstream.

Top module: `pla_array`

## Requirements
- R1: A literal code of 2'b10 makes the term need the input high, 2'b01 makes it need the input low, 2'b00 leaves the input out of the term, and 2'b11 forces the whole term to 0 whatever the inputs.
- R2: A term whose literal codes are all 2'b00 evaluates to 1.
- R3: A sum-plane bit of 1 connects a term to an output. An output with no connected term is 0.
- R4: In shared mode (PAL_MODE=0), one term may be connected to several outputs at once, and each of those outputs sees it.
- R5: In grouped mode (PAL_MODE=1), output o sees only terms o*G to o*G+G-1, where G = N_TERM/N_OUT. Sum-plane bits outside that group have no effect on the output.
- R6: While `load_en` is high, each rising clock edge shifts `load_bit` into bit 0 of the image, and the existing bits move up by one. The image is therefore sent most significant bit first.
  - The image is CFG_W = 2*N_IN*N_TERM + N_OUT*N_TERM bits wide.
  - The literal code for term t and input i occupies bits OR_W+2*(t*N_IN+i)+1 down to OR_W+2*(t*N_IN+i), where OR_W = N_OUT*N_TERM.
  - The connection bit for term t to output o is bit o*N_TERM+t.
- R7: While `load_en` is high, `dout` is all zeros.
- R8: Reset clears the whole image, so after reset every term is 1, no term is connected, and `dout` is 0 for every input.
- R9: Take the image with A=din[0], B=din[1], C=din[2] and terms T0=A, T1=B'C', T2=AC', T3=AB, T4=B'C. Connect them as F0=T0+T1, F1=T2+T3, F2=T1+T3, F3=T4+T0. In shared mode this image gives dout[0]=A+B'C', dout[1]=AC'+AB, dout[2]=B'C'+AB and dout[3]=B'C+A.
- R10: With `load_en` low, `dout` follows a change on `din` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shift register |
| rst_n | input | 1 | Active-low asynchronous reset, clears the image |
| load_en | input | 1 | Shift enable; while high, the outputs are forced to 0 |
| load_bit | input | 1 | Serial configuration data, most significant bit first |
| din | input | N_IN | Data inputs to the product plane |
| dout | output | N_OUT | Sum-of-products outputs |

## Verification
The in-RTL properties assume two things about the inputs. First, `load_en` and `load_bit` are stable around each rising edge. Second, `din` settles before the edge at which the outputs are sampled, since the array itself holds no timing state. The stimulus meets both conditions by changing every input one time unit after a rising edge. It then compares the outputs at the falling edge against a behavioural model. That model rebuilds the image bit by bit from the same shift stream and evaluates it from the requirement encodings. The grouped-mode instance is given images whose connection bits point outside each output's group, so that the ignored bits are seen at the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

   typedef enum logic [1:0] {
      LIT_DC   = 2'b00,
      LIT_NEG  = 2'b01,
      LIT_POS  = 2'b10,
      LIT_KILL = 2'b11
   } lit_e;

   // contribution of one input to one product term
   function automatic logic lit_pass(input logic [1:0] code, input logic x);
      logic r;
      unique case (code)
         LIT_DC:   r = 1'b1;
         LIT_NEG:  r = ~x;
         LIT_POS:  r = x;
         default:  r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
   parameter int W = 96
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         shift_bit,
   output logic [W-1:0] cfg_q
);

   initial begin
      if (W < 2) $error("pla_cfg_shift: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (shift_en) cfg_q <= {cfg_q[W-2:0], shift_bit};
   end

   // R6
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (cfg_q[0] == $past(shift_bit)) && (cfg_q[W-1:1] == $past(cfg_q[W-2:0])));

   // R6
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(cfg_q));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
   import pla_pkg::*;
#(
   parameter int N_IN   = 4,
   parameter int N_TERM = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2*N_IN*N_TERM-1:0]   lit_cfg,
   input  logic [N_IN-1:0]            din,
   output logic [N_TERM-1:0]          term
);

   localparam int ROW_W = 2*N_IN;

   initial begin
      if (N_IN < 1 || N_TERM < 1) $error("pla_and_plane: sizes must be positive");
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_IN-1:0] pass;
      logic [N_IN-1:0] killed;
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         assign pass[i]   = lit_pass(lit_cfg[t*ROW_W + 2*i +: 2], din[i]);
         assign killed[i] = (lit_cfg[t*ROW_W + 2*i +: 2] == LIT_KILL);
      end
      assign term[t] = &pass;

      // R1
      kill_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|killed) |-> !term[t]);

      // R2
      dc_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lit_cfg[t*ROW_W +: ROW_W] == '0) |-> term[t]);
   end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM   = 8,
   parameter int N_OUT    = 4,
   parameter bit PAL_MODE = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_OUT*N_TERM-1:0]   conn,
   input  logic [N_TERM-1:0]         term,
   output logic [N_OUT-1:0]          sum
);

   localparam int GRP = (N_TERM / N_OUT > 0) ? N_TERM / N_OUT : 1;

   initial begin
      if (PAL_MODE && (N_TERM % N_OUT != 0))
         $error("pla_or_plane: grouped mode needs N_TERM divisible by N_OUT");
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_TERM-1:0] reach;
      logic [N_TERM-1:0] row;
      if (PAL_MODE) begin : g_grouped
         for (genvar t = 0; t < N_TERM; t++) begin : g_bit
            assign reach[t] = (t / GRP == o);
         end
      end else begin : g_shared
         assign reach = '1;
      end
      assign row    = conn[o*N_TERM +: N_TERM] & reach;
      assign sum[o] = |(term & row);

      // R3
      no_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (conn[o*N_TERM +: N_TERM] == '0) |-> !sum[o]);

      if (PAL_MODE) begin : g_grp_chk
         // R5
         pal_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sum[o] |-> (|term[o*GRP +: GRP]));
      end
   end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
   parameter int N_IN     = 4,
   parameter int N_TERM   = 8,
   parameter int N_OUT    = 4,
   parameter bit PAL_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              load_bit,
   input  logic [N_IN-1:0]   din,
   output logic [N_OUT-1:0]  dout
);

   localparam int AND_W = 2*N_IN*N_TERM;
   localparam int OR_W  = N_OUT*N_TERM;
   localparam int CFG_W = AND_W + OR_W;

   logic [CFG_W-1:0]  img;
   logic [N_TERM-1:0] term;
   logic [N_OUT-1:0]  sum;

   pla_cfg_shift #(.W(CFG_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (load_en),
      .shift_bit (load_bit),
      .cfg_q     (img)
   );

   pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .clk     (clk),
      .rst_n   (rst_n),
      .lit_cfg (img[CFG_W-1:OR_W]),
      .din     (din),
      .term    (term)
   );

   pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_MODE(PAL_MODE)) u_or (
      .clk   (clk),
      .rst_n (rst_n),
      .conn  (img[OR_W-1:0]),
      .term  (term),
      .sum   (sum)
   );

   assign dout = load_en ? '0 : sum;

   // R7
   load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (dout == '0));

endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;

   localparam int N_IN   = 4;
   localparam int N_TERM = 8;
   localparam int N_OUT  = 4;
   localparam int OR_W   = N_OUT*N_TERM;
   localparam int CW     = 2*N_IN*N_TERM + OR_W;
   localparam int G      = N_TERM / N_OUT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_en = 1'b0;
   logic load_bit = 1'b0;
   logic [N_IN-1:0]  din = '0;
   logic [N_OUT-1:0] dout0, dout1;

   logic [CW-1:0] img;
   logic [CW-1:0] model_cfg = '0;
   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_MODE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bit(load_bit), .din(din), .dout(dout0));

   pla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_MODE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bit(load_bit), .din(din), .dout(dout1));

   // behavioural reference from the requirement encodings
   function automatic logic [N_OUT-1:0] ref_eval(input logic [CW-1:0] c, input logic [N_IN-1:0] d,
                                                 input bit pal, input bit busy);
      logic [N_OUT-1:0] r = '0;
      if (busy) return '0;
      for (int o = 0; o < N_OUT; o++) begin
         for (int t = 0; t < N_TERM; t++) begin
            bit tv = 1'b1;
            if (pal && (t / G != o)) continue;
            if (!c[o*N_TERM + t]) continue;
            for (int i = 0; i < N_IN; i++) begin
               logic [1:0] code = c[OR_W + 2*(t*N_IN + i) +: 2];
               if (code == 2'b10 && !d[i]) tv = 1'b0;
               if (code == 2'b01 &&  d[i]) tv = 1'b0;
               if (code == 2'b11)          tv = 1'b0;
            end
            if (tv) r[o] = 1'b1;
         end
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)       model_cfg <= '0;
      else if (load_en) model_cfg <= {model_cfg[CW-2:0], load_bit};
   end

   // per-cycle comparison against the model (R6, R7 during loads)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [N_OUT-1:0] e0, e1;
         e0 = ref_eval(model_cfg, din, 1'b0, load_en);
         e1 = ref_eval(model_cfg, din, 1'b1, load_en);
         vectors++;
         if (dout0 !== e0) begin
            errors++;
            $display("FAIL R6 model shared: got %b expected %b", dout0, e0);
         end
         if (dout1 !== e1) begin
            errors++;
            $display("FAIL R6 model grouped: got %b expected %b", dout1, e1);
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic check(input string req, input logic [N_OUT-1:0] got, input logic [N_OUT-1:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic set_lit(input int t, input int i, input logic [1:0] code);
      img[OR_W + 2*(t*N_IN + i) +: 2] = code;
   endtask

   task automatic set_conn(input int t, input int o);
      img[o*N_TERM + t] = 1'b1;
   endtask

   task automatic load_image();
      for (int k = CW-1; k >= 0; k--) begin
         @(posedge clk); #1;
         load_en  = 1'b1;
         load_bit = img[k];
         if (k == CW-1) begin
            #1 check("R7 outputs masked during load", dout0 | dout1, '0);
         end
      end
      @(posedge clk); #1;
      load_en = 1'b0;
   endtask

   initial begin
      logic [N_OUT-1:0] exp;
      logic a, b, c;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: reset image -> all outputs 0
      for (int v = 0; v < 16; v++) begin
         @(posedge clk); #1 din = v[N_IN-1:0];
         #1 check("R8 reset state shared", dout0, '0);
         check("R8 reset state grouped", dout1, '0);
      end

      // R2: all don't-care term 0 to out0, R3: other outputs unconnected
      img = '0;
      set_conn(0, 0);
      load_image();
      for (int v = 0; v < 16; v += 5) begin
         @(posedge clk); #1 din = v[N_IN-1:0];
         #1 check("R2 all-dc term is 1 / R3 unconnected 0", dout0, 4'b0001);
      end

      // R9 / R4 / R1: reference personality, A=din0 B=din1 C=din2
      img = '0;
      set_lit(0, 0, 2'b10);
      set_lit(1, 1, 2'b01); set_lit(1, 2, 2'b01);
      set_lit(2, 0, 2'b10); set_lit(2, 2, 2'b01);
      set_lit(3, 0, 2'b10); set_lit(3, 1, 2'b10);
      set_lit(4, 1, 2'b01); set_lit(4, 2, 2'b10);
      set_lit(5, 0, 2'b11);                       // killed term (R1)
      set_conn(0, 0); set_conn(1, 0);
      set_conn(2, 1); set_conn(3, 1);
      set_conn(1, 2); set_conn(3, 2);
      set_conn(4, 3); set_conn(0, 3);
      load_image();
      for (int v = 0; v < 16; v++) begin
         @(posedge clk); #1 din = v[N_IN-1:0];
         a = din[0]; b = din[1]; c = din[2];
         exp[0] = a | (~b & ~c);
         exp[1] = (a & ~c) | (a & b);
         exp[2] = (~b & ~c) | (a & b);
         exp[3] = (~b & c) | a;
         #1 check("R9 reference functions (R4 shared T0,T1,T3)", dout0, exp);
      end

      // R10: output follows din with no clock edge
      @(negedge clk);
      din = 4'b0000;
      #2 check("R10 combinational din=0000", dout0, 4'b0101);
      din = 4'b0100;
      #2 check("R10 combinational din=0100", dout0, 4'b1000);
      @(posedge clk); #1;

      // R1: killed term connected alone to out1 stays 0
      img = '0;
      set_lit(2, 0, 2'b11);
      set_conn(2, 1);
      load_image();
      for (int v = 0; v < 16; v += 3) begin
         @(posedge clk); #1 din = v[N_IN-1:0];
         #1 check("R1 forced-zero term", dout0, '0);
      end

      // R5: grouped mode ignores connections outside the group
      img = '0;
      set_conn(5, 0);   // outside out0 group (terms 0,1)
      set_conn(2, 1);   // inside out1 group (terms 2,3)
      set_conn(0, 3);   // outside out3 group (terms 6,7)
      set_conn(0, 2);   // outside out2 group (terms 4,5)
      load_image();
      @(posedge clk); #1 din = 4'b1010;
      #1 check("R5 grouped ignores outside bits", dout1, 4'b0010);
      check("R4 shared sees same bits", dout0, 4'b1111);

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule